// File: doc/BRIEF.md
# Four-Channel Capture/Compare/PWM Timer

This block is a 16-bit up-counter shared by four channels. The counter runs from zero to a programmable top value and then returns to zero. On each return it emits a one-cycle trigger pulse that other logic can use to start timed work. Software sets the top value, a run bit, a dead-time length, a mode per channel and a threshold per channel through a write-only port of address, data and strobe.

Each channel works in one of three modes, picked at run time. In capture mode a chosen edge on the channel's event input copies the counter into that channel's capture register. A status flag marks the register as unread, and a second flag records a capture that arrived before the previous one was read. In compare mode the channel's primary output shows whether the counter has reached the threshold. In PWM mode the primary output is high while the counter is below the threshold and the complementary output is high otherwise. Threshold writes in PWM mode go to a holding register and only reach the comparator at the next wrap. A programmable dead time holds back the rising edge of both PWM outputs.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter is 0, the run bit is 0, the top value is 0xFFFF, every channel is off, and all outputs, flags and the wrap pulse are low.
- R2: Writing address 1 with bit 0 set makes the counter advance by one each clock. When it holds the top value (address 0) the next value is 0. With bit 0 clear the counter holds its value.
- R3: `wrap_pulse` is high for exactly the one cycle in which the counter shows 0 after having shown the top value while running.
- R4: Address 4+n configures channel n: bits [1:0] give the mode (0 off, 1 capture, 2 compare, 3 PWM) and bits [3:2] give the capture edges (bit 2 rising, bit 3 falling). In off and capture modes both outputs of the channel stay low. In compare mode `out_n` stays low.
- R5: In capture mode, a selected edge of `evt_in[n]` (seen between two clock samples) stores into the channel's slot of `cap_val` the counter value shown in the cycle the new input level is present, and sets `cap_full[n]`. An edge that is not selected changes neither.
- R6: A one-cycle `cap_rd[n]` clears `cap_full[n]`. A capture while `cap_full[n]` is set (and not being read in the same cycle) sets `cap_ovf[n]`, which stays set until channel n's configuration is written.
- R7: In compare mode `out_p[n]` equals (counter ≥ threshold) for the counter value of the previous cycle. A threshold write (address 8+n) takes effect on the next clock.
- R8: In PWM mode with zero dead time, `out_p[n]` equals (counter < threshold) for the previous counter value and `out_n[n]` is its inverse. A threshold written in this mode is applied only when the counter wraps, so the period under way keeps the old threshold.
- R9: Address 2 sets a dead time of D cycles. In PWM mode each rising edge of `out_p[n]` and `out_n[n]` comes D cycles after the underlying level change, falling edges are not delayed, and the two outputs are never high together. For a threshold T and period P (with D below both T and P−T), `out_p` is high T−D cycles and `out_n` P−T−D cycles per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| evt_in | input | 4 | Per-channel capture event inputs, synchronous to clk |
| cap_rd | input | 4 | Per-channel capture read acknowledge |
| cnt_out | output | 16 | Current counter value |
| cap_val | output | 64 | Captured values, channel n in bits [16n+15:16n] |
| cap_full | output | 4 | Unread capture per channel |
| cap_ovf | output | 4 | Sticky capture overrun per channel |
| out_p | output | 4 | Primary channel outputs |
| out_n | output | 4 | Complementary PWM outputs |
| wrap_pulse | output | 1 | One-cycle pulse on counter wrap |

## Verification
The assertions assume that `evt_in` and `cap_rd` are already synchronous to the clock and that `cap_rd` is a single-cycle strobe. They also assume that the top value and the run bit change only through the write port, so the counter step and the wrap origin can be read from registered state. The bench drives all inputs at the falling edge and writes registers one cycle at a time. It sets the dead time below both the high and low portions of each PWM period, which keeps the pulse-width counts in R9 meaningful.

// File: rtl/cc_timer.sv
`timescale 1ns/1ps
module cc_timer #(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int DTW = 8,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [NCH-1:0]    evt_in,
  input  logic [NCH-1:0]    cap_rd,
  output logic [CW-1:0]     cnt_out,
  output logic [NCH*CW-1:0] cap_val,
  output logic [NCH-1:0]    cap_full,
  output logic [NCH-1:0]    cap_ovf,
  output logic [NCH-1:0]    out_p,
  output logic [NCH-1:0]    out_n,
  output logic              wrap_pulse
);
  localparam logic [1:0] M_OFF = 2'd0, M_CAP = 2'd1, M_CMP = 2'd2, M_PWM = 2'd3;
  localparam logic [AW-1:0] A_TOP = AW'(0), A_RUN = AW'(1), A_DT = AW'(2);
  localparam int A_CFG = 4, A_THR = 8;

  logic [CW-1:0]  cnt_q, top_q;
  logic [DTW-1:0] dt_q;
  logic           run_q;
  logic           wrap;
  logic [NCH-1:0] is_pwm, is_cmp;

  assign wrap    = run_q && (cnt_q == top_q);
  assign cnt_out = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      top_q      <= '1;
      dt_q       <= '0;
      run_q      <= 1'b0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= wrap;
      if (wrap)       cnt_q <= '0;
      else if (run_q) cnt_q <= cnt_q + CW'(1);
      if (wr_en && wr_addr == A_TOP) top_q <= wr_data;
      if (wr_en && wr_addr == A_RUN) run_q <= wr_data[0];
      if (wr_en && wr_addr == A_DT)  dt_q  <= wr_data[DTW-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] CFG_ADDR = AW'(A_CFG + i);
    localparam logic [AW-1:0] THR_ADDR = AW'(A_THR + i);
    logic [1:0]     mode, edg;
    logic [CW-1:0]  thr_buf, thr_act, cap_q;
    logic           evt_q, raw_q, raw_d, hit, full_q, ovf_q, cfg_wr, thr_wr, dt_done;
    logic [DTW-1:0] dtc;

    assign cfg_wr  = wr_en && wr_addr == CFG_ADDR;
    assign thr_wr  = wr_en && wr_addr == THR_ADDR;
    assign hit     = (mode == M_CAP) &&
                     ((edg[0] && evt_in[i] && !evt_q) || (edg[1] && !evt_in[i] && evt_q));
    assign raw_d   = (mode == M_PWM) ? (cnt_q < thr_act) :
                     (mode == M_CMP) ? (cnt_q >= thr_act) : 1'b0;
    assign dt_done = (dtc == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode    <= M_OFF;
        edg     <= '0;
        thr_buf <= '0;
        thr_act <= '0;
        cap_q   <= '0;
        evt_q   <= 1'b0;
        raw_q   <= 1'b0;
        full_q  <= 1'b0;
        ovf_q   <= 1'b0;
        dtc     <= '0;
      end else begin
        evt_q <= evt_in[i];
        if (cfg_wr) begin
          mode   <= wr_data[1:0];
          edg    <= wr_data[3:2];
          ovf_q  <= 1'b0;
          full_q <= 1'b0;
        end
        if (wrap && mode == M_PWM) thr_act <= thr_buf;
        if (thr_wr) begin
          thr_buf <= wr_data;
          if (mode != M_PWM) thr_act <= wr_data;
        end
        if (hit) begin
          cap_q  <= cnt_q;
          full_q <= 1'b1;
          if (full_q && !cap_rd[i]) ovf_q <= 1'b1;
        end else if (cap_rd[i]) begin
          full_q <= 1'b0;
        end
        raw_q <= raw_d;
        if (raw_d != raw_q) dtc <= dt_q;
        else if (!dt_done)  dtc <= dtc - DTW'(1);
      end
    end

    assign is_pwm[i] = (mode == M_PWM);
    assign is_cmp[i] = (mode == M_CMP);
    assign out_p[i]  = is_pwm[i] ? (raw_q && dt_done) : (is_cmp[i] && raw_q);
    assign out_n[i]  = is_pwm[i] && !raw_q && dt_done;
    assign cap_val[i*CW +: CW] = cap_q;
    assign cap_full[i] = full_q;
    assign cap_ovf[i]  = ovf_q;
  end
endmodule

// File: rtl/cc_timer_chk.sv
`timescale 1ns/1ps
module cc_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  cnt_out,
  input logic [CW-1:0]  top,
  input logic           run,
  input logic           wrap_pulse,
  input logic [NCH-1:0] out_p,
  input logic [NCH-1:0] out_n,
  input logic [NCH-1:0] is_pwm,
  input logic [NCH-1:0] is_cmp,
  input logic [NCH-1:0] cap_full,
  input logic [NCH-1:0] cap_ovf
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_out != top) |=> cnt_out == $past(cnt_out) + CW'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_out));
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> cnt_out == '0);
  // R3
  wrap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> ($past(run) && $past(cnt_out) == $past(top)));
  // R4
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_n & ~is_pwm) == '0) && ((out_p & ~(is_pwm | is_cmp)) == '0));
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_p & out_n) == '0);
  // R6
  ovf_need_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_ovf & ~$past(cap_ovf)) & ~$past(cap_full)) == '0);
endmodule

bind cc_timer cc_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_out(cnt_out), .top(top_q), .run(run_q),
  .wrap_pulse(wrap_pulse), .out_p(out_p), .out_n(out_n), .is_pwm(is_pwm),
  .is_cmp(is_cmp), .cap_full(cap_full), .cap_ovf(cap_ovf)
);

// File: tb/cc_timer_test.sv
`timescale 1ns/1ps
module cc_timer_test;
  localparam int CW = 16, NCH = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NCH-1:0] evt_in = '0, cap_rd = '0;
  logic [CW-1:0] cnt_out;
  logic [NCH*CW-1:0] cap_val;
  logic [NCH-1:0] cap_full, cap_ovf, out_p, out_n;
  logic wrap_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  cc_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_in(evt_in), .cap_rd(cap_rd), .cnt_out(cnt_out), .cap_val(cap_val), .cap_full(cap_full),
    .cap_ovf(cap_ovf), .out_p(out_p), .out_n(out_n), .wrap_pulse(wrap_pulse));

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_win(input int n, input int ch, output int pc, output int nc, output int both);
    pc = 0; nc = 0; both = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pc += int'(out_p[ch]); nc += int'(out_n[ch]);
      both += int'(out_p[ch] & out_n[ch]);
    end
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    chk("R1 cnt", cnt_out, 0);
    chk("R1 outputs", {out_p, out_n, cap_full, cap_ovf}, 0);
    chk("R1 wrap", wrap_pulse, 0);
    v = cnt_out;
    repeat (5) @(negedge clk);
    chk("R2 idle hold", cnt_out, v);
  endtask

  task automatic t_count();
    logic [CW-1:0] prev, v;
    int wraps = 0;
    wr(4'd0, 16'd9);
    wr(4'd1, 16'd1);
    prev = cnt_out;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R2 step", cnt_out, (prev == 9) ? 0 : prev + 1);
      chk("R3 wrap pulse", wrap_pulse, (prev == 9) ? 1 : 0);
      if (wrap_pulse) wraps++;
      prev = cnt_out;
    end
    chk("R3 wrap count", wraps, 3);
    wr(4'd1, 16'd0);
    v = cnt_out;
    repeat (4) @(negedge clk);
    chk("R2 stopped hold", cnt_out, v);
    wr(4'd1, 16'd1);
  endtask

  task automatic t_compare();
    logic [CW-1:0] prev;
    wr(4'd4, 16'd2);
    wr(4'd8, 16'd6);
    repeat (3) @(negedge clk);
    prev = cnt_out;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R7 compare level", out_p[0], (prev >= 6) ? 1 : 0);
      chk("R4 compare out_n low", out_n[0], 0);
      chk("R4 off channel low", {out_p[1], out_n[1]}, 0);
      prev = cnt_out;
    end
    wr(4'd8, 16'd2);
    prev = cnt_out;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R7 immediate threshold", out_p[0], (prev >= 2) ? 1 : 0);
      prev = cnt_out;
    end
  endtask

  task automatic t_pwm();
    int pc, nc, bc;
    logic [CW-1:0] prev;
    wr(4'd2, 16'd0);
    wr(4'd6, 16'd3);
    wr(4'd10, 16'd4);
    repeat (25) @(negedge clk);
    prev = cnt_out;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R8 pwm level", out_p[2], (prev < 4) ? 1 : 0);
      chk("R8 pwm inverse", out_n[2], (prev < 4) ? 0 : 1);
      prev = cnt_out;
    end
    while (!wrap_pulse) @(negedge clk);
    pc = int'(out_p[2]);
    for (int k = 1; k < 10; k++) begin
      if (k == 4) begin wr_en = 1'b1; wr_addr = 4'd10; wr_data = 16'd7; end
      if (k == 5) wr_en = 1'b0;
      @(negedge clk);
      pc += int'(out_p[2]);
    end
    wr_en = 1'b0;
    chk("R8 buffered period keeps old", pc, 4);
    count_win(10, 2, pc, nc, bc);
    chk("R8 new threshold after wrap", pc, 7);
  endtask

  task automatic t_dead();
    int pc, nc, bc;
    wr(4'd10, 16'd4);
    wr(4'd2, 16'd2);
    repeat (25) @(negedge clk);
    count_win(10, 2, pc, nc, bc);
    chk("R9 primary width", pc, 2);
    chk("R9 complementary width", nc, 4);
    chk("R9 no overlap", bc, 0);
    wr(4'd2, 16'd0);
  endtask

  task automatic t_capture();
    logic [CW-1:0] v1, v2, held;
    wr(4'd7, 16'd5);
    chk("R4 capture outputs low", {out_p[3], out_n[3]}, 0);
    v1 = cnt_out; evt_in[3] = 1'b1;
    @(negedge clk);
    chk("R5 rising capture value", cap_val[3*CW +: CW], v1);
    chk("R5 full set", cap_full[3], 1);
    cap_rd[3] = 1'b1;
    @(negedge clk);
    cap_rd[3] = 1'b0;
    chk("R6 read clears full", cap_full[3], 0);
    held = cap_val[3*CW +: CW];
    evt_in[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 falling ignored full", cap_full[3], 0);
    chk("R5 falling ignored value", cap_val[3*CW +: CW], held);
    wr(4'd7, 16'd13);
    v1 = cnt_out; evt_in[3] = 1'b1;
    @(negedge clk);
    chk("R5 both-edge rising", cap_val[3*CW +: CW], v1);
    chk("R6 no overrun on first", cap_ovf[3], 0);
    @(negedge clk);
    v2 = cnt_out; evt_in[3] = 1'b0;
    @(negedge clk);
    chk("R5 both-edge falling", cap_val[3*CW +: CW], v2);
    chk("R6 overrun set", cap_ovf[3], 1);
    cap_rd[3] = 1'b1;
    @(negedge clk);
    cap_rd[3] = 1'b0;
    chk("R6 full cleared", cap_full[3], 0);
    chk("R6 overrun sticky", cap_ovf[3], 1);
    wr(4'd7, 16'd13);
    chk("R6 config clears overrun", cap_ovf[3], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_compare();
    t_pwm();
    t_dead();
    t_capture();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule